// File: doc/BRIEF.md
# Byte Elastic Buffer Between Two Clock Domains

This block carries a stream of bytes from a producer running on a 60 MHz link-side clock to a consumer running on an application clock. The application clock is independent of the link clock. For correct flow it should run faster than half the link clock and slower than four times it. Storage is a dual-port memory of `2**ADDR_W` bytes. The default `ADDR_W = 11` gives 2048 bytes, or 16 Kbit.

The producer and the consumer each use a handshake of their own. The producer watches `wr_req`, which stays high while less than half of the storage is occupied. While it is high, the producer pushes bytes with `wr_stb`. The consumer raises `rd_req` to ask for a byte. The buffer answers one application-clock cycle later with `rd_stb` high and the byte on `rd_data`. No strobe is returned when nothing is stored. The two pointers cross between the domains as Gray codes through two-stage synchronizers. The lowest and highest address bit of each pointer are brought out as test points, so that flow control can be watched on a probe.

Top module: `byte_elastic_buffer`

## Requirements
- R1: While `rst` is high, and right after it falls, both pointers are zero. In that state `rd_empty` = 1, `rd_stb` = 0, `wr_req` = 1, `wr_tp` = 2'b00 and `rd_tp` = 2'b00. The reset is asynchronous and clears both clock domains.
- R2: Bytes leave on `rd_data` in the same order they were accepted on `wr_data`, without loss or duplication.
- R3: A `rd_req` sampled high on a rising `rd_clk` edge while a byte is stored gives `rd_stb` = 1 after that same edge. In the cycle `rd_stb` is high, `rd_data` holds the oldest stored byte.
- R4: `rd_empty` is 1 whenever no byte is visible to the read side. A `rd_req` made while `rd_empty` is 1 gives no strobe and leaves the read pointer unchanged.
- R5: `wr_req` is 1 while fewer than `2**(ADDR_W-1)` bytes are stored and 0 at or above that level. It returns to 1 once reads bring the level back below half.
- R6: With `2**ADDR_W` bytes stored, a further `wr_stb` is dropped. The write pointer does not move, and the dropped byte never appears on `rd_data`.
- R7: The read pointer never passes the write pointer. Every strobed byte is one that was written.
- R8: `wr_tp` = {write pointer bit `ADDR_W-1`, write pointer bit 0} and `rd_tp` = {read pointer bit `ADDR_W-1`, read pointer bit 0}. Each pointer counts accepted transfers since reset.
- R9: Each pointer crosses domains as a Gray code that changes in at most one bit per cycle of its own clock. A single written byte clears `rd_empty` within 8 `rd_clk` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Asynchronous active-high reset for both domains |
| wr_clk | input | 1 | Link-side (producer) clock, 60 MHz nominal |
| wr_data | input | DATA_W | Byte to store |
| wr_stb | input | 1 | Store `wr_data` on this rising `wr_clk` edge |
| wr_req | output | 1 | High while occupancy is below half capacity |
| wr_tp | output | 2 | Write pointer test bits {MSB of address, bit 0} |
| rd_clk | input | 1 | Application (consumer) clock |
| rd_req | input | 1 | Ask for one byte |
| rd_stb | output | 1 | `rd_data` carries a byte this cycle |
| rd_data | output | DATA_W | Byte delivered with `rd_stb` |
| rd_empty | output | 1 | No byte visible to the read side |
| rd_tp | output | 2 | Read pointer test bits {MSB of address, bit 0} |

## Verification
The cycle-by-cycle assertions check four things: the write-side occupancy never exceeds capacity, and the read-side view never shows the read pointer past the write pointer. A write while full never moves the write pointer, and every strobe follows an accepted request one cycle earlier. They also check that `wr_req` is never high at or above half occupancy, and that each published Gray pointer steps in at most one bit. The bench scenarios cover the rest: byte order across fills of different lengths, the threshold at exactly half, the dropped byte at full, no strobe at empty, test-point values after known transfer counts, and the return to the reset state after a mid-stream reset.

// File: rtl/efb_pkg.sv
package efb_pkg;
  localparam int DATA_W_DEF = 8;
  localparam int ADDR_W_DEF = 11;

  function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/efb_sync.sv
module efb_sync #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/efb_ram.sv
module efb_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 11
) (
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge rd_clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/efb_wr_side.sv
module efb_wr_side
  import efb_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [ADDR_W:0]   rd_gray_s,
  output logic [ADDR_W:0]   wr_gray,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              accept,
  output logic              below_half,
  output logic [1:0]        tp
);
  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] FULL_LVL = {1'b1, {ADDR_W{1'b0}}};
  localparam logic [PW-1:0] HALF_LVL = {2'b01, {(ADDR_W-1){1'b0}}};

  logic [PW-1:0] wbin, wbin_nx, rbin_s, fill, fill_nx;
  logic          full;

  always_comb begin
    rbin_s  = PW'(gray_to_bin(32'(rd_gray_s)));
    fill    = wbin - rbin_s;
    full    = (fill == FULL_LVL);
    accept  = push & ~full;
    wbin_nx = wbin + PW'(accept);
    fill_nx = wbin_nx - rbin_s;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      wbin       <= '0;
      wr_gray    <= '0;
      below_half <= 1'b1;
    end else begin
      wbin       <= wbin_nx;
      wr_gray    <= PW'(bin_to_gray(32'(wbin_nx)));
      below_half <= (fill_nx < HALF_LVL);
    end
  end

  assign wr_addr = wbin[ADDR_W-1:0];
  assign tp      = {wbin[ADDR_W-1], wbin[0]};

  // R6: occupancy seen by the writer never exceeds capacity
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    fill <= FULL_LVL);
  // R6: a push while full leaves the write pointer where it was
  assert_full_drop_R6: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> $stable(wbin));
  // R5: request high only below half occupancy
  assert_req_below_half_R5: assert property (@(posedge clk) disable iff (rst)
    below_half |-> (fill < HALF_LVL));
  // R9: published write pointer moves by one Gray step at most
  assert_gray_step_wr_R9: assert property (@(posedge clk) disable iff (rst)
    $countones(wr_gray ^ $past(wr_gray)) <= 1);
endmodule

// File: rtl/efb_rd_side.sv
module efb_rd_side
  import efb_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pull,
  input  logic [ADDR_W:0]   wr_gray_s,
  output logic [ADDR_W:0]   rd_gray,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              fetch,
  output logic              stb,
  output logic              empty,
  output logic [1:0]        tp
);
  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] FULL_LVL = {1'b1, {ADDR_W{1'b0}}};

  logic [PW-1:0] rbin, rbin_nx, wbin_s, level;

  always_comb begin
    wbin_s  = PW'(gray_to_bin(32'(wr_gray_s)));
    fetch   = pull & ~empty;
    rbin_nx = rbin + PW'(fetch);
    level   = wbin_s - rbin;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      rbin    <= '0;
      rd_gray <= '0;
      empty   <= 1'b1;
      stb     <= 1'b0;
    end else begin
      rbin    <= rbin_nx;
      rd_gray <= PW'(bin_to_gray(32'(rbin_nx)));
      empty   <= (rbin_nx == wbin_s);
      stb     <= fetch;
    end
  end

  assign rd_addr = rbin[ADDR_W-1:0];
  assign tp      = {rbin[ADDR_W-1], rbin[0]};

  // R7: reader never runs ahead of the synchronized writer
  assert_no_pass_R7: assert property (@(posedge clk) disable iff (rst)
    level <= FULL_LVL);
  // R3: a strobe always answers a request accepted one cycle earlier
  assert_strobe_after_req_R3: assert property (@(posedge clk) disable iff (rst)
    stb |-> $past(pull && !empty));
  // R9: published read pointer moves by one Gray step at most
  assert_gray_step_rd_R9: assert property (@(posedge clk) disable iff (rst)
    $countones(rd_gray ^ $past(rd_gray)) <= 1);
endmodule

// File: rtl/byte_elastic_buffer.sv
module byte_elastic_buffer
  import efb_pkg::*;
#(
  parameter int DATA_W = DATA_W_DEF,
  parameter int ADDR_W = ADDR_W_DEF
) (
  input  logic              rst,
  input  logic              wr_clk,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_stb,
  output logic              wr_req,
  output logic [1:0]        wr_tp,
  input  logic              rd_clk,
  input  logic              rd_req,
  output logic              rd_stb,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_empty,
  output logic [1:0]        rd_tp
);
  localparam int PW = ADDR_W + 1;

  logic [PW-1:0]     wr_gray, wr_gray_s, rd_gray, rd_gray_s;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic              wr_accept, rd_fetch;

  efb_wr_side #(.ADDR_W(ADDR_W)) u_wr (
    .clk(wr_clk), .rst(rst), .push(wr_stb), .rd_gray_s(rd_gray_s),
    .wr_gray(wr_gray), .wr_addr(wr_addr), .accept(wr_accept),
    .below_half(wr_req), .tp(wr_tp)
  );

  efb_rd_side #(.ADDR_W(ADDR_W)) u_rd (
    .clk(rd_clk), .rst(rst), .pull(rd_req), .wr_gray_s(wr_gray_s),
    .rd_gray(rd_gray), .rd_addr(rd_addr), .fetch(rd_fetch),
    .stb(rd_stb), .empty(rd_empty), .tp(rd_tp)
  );

  efb_sync #(.W(PW)) u_sync_w2r (
    .clk(rd_clk), .rst(rst), .d(wr_gray), .q(wr_gray_s)
  );

  efb_sync #(.W(PW)) u_sync_r2w (
    .clk(wr_clk), .rst(rst), .d(rd_gray), .q(rd_gray_s)
  );

  efb_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .wr_clk(wr_clk), .wr_en(wr_accept), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_clk(rd_clk), .rd_en(rd_fetch), .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: tb/byte_elastic_buffer_tb_top.sv
module byte_elastic_buffer_tb_top;
  localparam int AW   = 5;
  localparam int DW   = 8;
  localparam int CAP  = 1 << AW;
  localparam int HALF = CAP / 2;
  localparam int NVEC = 5;
  // {byte count, first byte, step}
  localparam logic [23:0] VEC [NVEC] = '{
    {8'd1,  8'h11, 8'd0},
    {8'd5,  8'hA0, 8'd1},
    {8'd15, 8'h03, 8'd7},
    {8'd16, 8'h80, 8'd3},
    {8'd20, 8'hF0, 8'd9}
  };

  logic          rst, wr_clk, rd_clk, wr_stb, rd_req;
  logic [DW-1:0] wr_data, rd_data;
  logic          wr_req, rd_stb, rd_empty;
  logic [1:0]    wr_tp, rd_tp;

  int checks = 0, errors = 0, wr_total = 0, rd_total = 0;
  bit done = 0;

  byte_elastic_buffer #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .rst(rst), .wr_clk(wr_clk), .wr_data(wr_data), .wr_stb(wr_stb),
    .wr_req(wr_req), .wr_tp(wr_tp), .rd_clk(rd_clk), .rd_req(rd_req),
    .rd_stb(rd_stb), .rd_data(rd_data), .rd_empty(rd_empty), .rd_tp(rd_tp)
  );

  initial rd_clk = 0;
  always #5 rd_clk = ~rd_clk;
  initial wr_clk = 0;
  always #8 wr_clk = ~wr_clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_byte(input logic [7:0] b);
    wr_data = b;
    wr_stb  = 1'b1;
    @(negedge wr_clk);
    wr_stb  = 1'b0;
  endtask

  task automatic read_expect(input logic [7:0] b, input string req);
    rd_req = 1'b1;
    @(negedge rd_clk);
    rd_req = 1'b0;
    check(rd_stb === 1'b1, {req, " strobe"}, int'(rd_stb), 1);
    check(rd_data === b, {req, " data"}, int'(rd_data), int'(b));
  endtask

  task automatic settle();
    repeat (8) @(negedge rd_clk);
  endtask

  task automatic check_tp(input string req);
    logic [1:0] ew, er;
    ew = {wr_total[AW-1], wr_total[0]};
    er = {rd_total[AW-1], rd_total[0]};
    check(wr_tp === ew, {req, " wr_tp"}, int'(wr_tp), int'(ew));
    check(rd_tp === er, {req, " rd_tp"}, int'(rd_tp), int'(er));
  endtask

  task automatic check_reset_state(input string tag);
    check(rd_empty === 1'b1, {tag, " R1 rd_empty"}, int'(rd_empty), 1);
    check(rd_stb === 1'b0, {tag, " R1 rd_stb"}, int'(rd_stb), 0);
    check(wr_req === 1'b1, {tag, " R1 wr_req"}, int'(wr_req), 1);
    check(wr_tp === 2'b00, {tag, " R1 wr_tp"}, int'(wr_tp), 0);
    check(rd_tp === 2'b00, {tag, " R1 rd_tp"}, int'(rd_tp), 0);
  endtask

  initial begin
    repeat (200000) @(posedge rd_clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; wr_stb = 0; rd_req = 0; wr_data = '0;
    repeat (4) @(negedge rd_clk);
    check_reset_state("during reset");
    rst = 0;
    settle();
    check_reset_state("after reset");

    // Table-driven fills and drains: R2 R3 R5 R8 R9
    for (int v = 0; v < NVEC; v++) begin
      int n;
      logic [7:0] st, sp;
      n  = int'(VEC[v][23:16]);
      st = VEC[v][15:8];
      sp = VEC[v][7:0];
      @(negedge wr_clk);
      for (int i = 0; i < n; i++) write_byte(8'(st + i * sp));
      wr_total += n;
      settle();
      check(rd_empty === 1'b0, "R9 byte visible", int'(rd_empty), 0);
      check(wr_req === (n < HALF), "R5 level request", int'(wr_req), int'(n < HALF));
      check_tp("R8 after writes");
      @(negedge rd_clk);
      for (int i = 0; i < n; i++) read_expect(8'(st + i * sp), "R2 R3 order");
      rd_total += n;
      check(rd_empty === 1'b1, "R4 empty after drain", int'(rd_empty), 1);
      check_tp("R8 after reads");
      settle();
      check(wr_req === 1'b1, "R5 request back", int'(wr_req), 1);
    end

    // Full: extra write dropped (R6), then read all back
    @(negedge wr_clk);
    for (int i = 0; i < CAP; i++) write_byte(8'(8'h40 + i));
    wr_total += CAP;
    settle();
    check(wr_req === 1'b0, "R5 request low at full", int'(wr_req), 0);
    @(negedge wr_clk);
    write_byte(8'hEE);
    settle();
    check_tp("R6 pointer held on dropped write");
    @(negedge rd_clk);
    for (int i = 0; i < CAP; i++) read_expect(8'(8'h40 + i), "R6 R7 contents at full");
    rd_total += CAP;
    check(rd_empty === 1'b1, "R7 empty after full drain", int'(rd_empty), 1);

    // Empty: request makes no strobe (R4)
    rd_req = 1'b1;
    @(negedge rd_clk);
    rd_req = 1'b0;
    check(rd_stb === 1'b0, "R4 no strobe when empty", int'(rd_stb), 0);
    @(negedge rd_clk);
    check(rd_stb === 1'b0, "R4 no late strobe", int'(rd_stb), 0);
    check_tp("R4 read pointer held");

    // Mid-stream reset (R1)
    @(negedge wr_clk);
    for (int i = 0; i < 3; i++) write_byte(8'(8'h70 + i));
    settle();
    rst = 1;
    repeat (3) @(negedge rd_clk);
    rst = 0;
    wr_total = 0;
    rd_total = 0;
    settle();
    check_reset_state("mid-stream");
    @(negedge wr_clk);
    write_byte(8'h5A);
    write_byte(8'hC3);
    wr_total = 2;
    settle();
    @(negedge rd_clk);
    read_expect(8'h5A, "R2 after reset first");
    read_expect(8'hC3, "R2 after reset second");
    rd_total = 2;
    check_tp("R8 after reset traffic");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule